// File: doc/BRIEF.md
# Self-Refresh Exit Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It brings the memory out of self refresh and holds it safe until ordinary traffic may resume. While the device sleeps, the sequencer keeps clock enable low. When an exit is requested and the clock is reported stable, it raises clock enable. It then times two separate windows. The short one, tXSNR, marks the point where ordinary commands may be issued again. The long one, tXSRD, marks the point where on-die termination may be turned back on.

Throughout the exit, the sequencer's command pins carry only an idle encoding. A parameter picks between NOP and Deselect. The block also tracks the extra auto refresh that must follow every exit. A later request to go back into self refresh is refused, with a one-cycle error pulse, until such a refresh has been issued after the short window and its tRFC recovery has run out. When a return is accepted, the block drops clock enable and presents the self-refresh entry encoding for exactly one cycle.

Top module: `sr_exit_seq`

## Requirements
- R1: Out of reset, ckeOut, odtAllow, cmdReady, refPending and reentryErr are all 0, and the command pins carry the idle encoding.
- R2: ckeOut rises one cycle after a clock edge that samples exitReq and clkStable both high while the device sleeps. While clkStable is low, exitReq leaves ckeOut low.
- R3: cmdReady rises exactly XSNR_CYC cycles after ckeOut rises, and is low while ckeOut is low.
- R4: odtAllow stays low until exactly XSRD_CYC cycles after ckeOut rises. It then goes high and stays high until the next entry into self refresh.
- R5: Apart from the single entry cycle, the command pins carry the idle encoding: rasN=casN=weN=1, with csN=0 for NOP (IDLE_DESELECT=0) or csN=1 for Deselect (IDLE_DESELECT=1).
- R6: Once raised, ckeOut stays high until an accepted re-entry request. A refused request leaves it high.
- R7: refPending goes high with ckeOut. A refIssued pulse counts only when cmdReady is high and no tRFC recovery is running; other pulses are ignored. refPending falls exactly RFC_CYC cycles after the clock edge that samples the pulse that counts.
- R8: A reentryReq sampled while refPending is high, cmdReady is low, or the device sleeps is refused. The refusal shows as reentryErr high for the following cycle.
- R9: An accepted reentryReq makes ckeOut, cmdReady and odtAllow low on the next cycle. For that one cycle the pins carry csN=0, rasN=0, casN=0, weN=1, and they return to idle on the cycle after.
- R10: After a return to self refresh, a new exit restarts both exit windows and the refresh obligation from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset; the device is taken as sleeping |
| exitReq | input | 1 | Request to leave self refresh |
| clkStable | input | 1 | Memory clock has settled |
| reentryReq | input | 1 | Request to return to self refresh |
| refIssued | input | 1 | Strobe: an auto refresh was issued this cycle |
| ckeOut | output | 1 | Clock enable to the memory |
| odtAllow | output | 1 | Termination may be enabled (tXSRD elapsed) |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cmdReady | output | 1 | Ordinary commands may be issued (tXSNR elapsed) |
| refPending | output | 1 | Post-exit refresh or its tRFC still outstanding |
| reentryErr | output | 1 | One-cycle pulse: re-entry request refused |

## Verification
The hardest case to reach from the ports is a refresh strobe that must be ignored. This can happen in two ways: it arrives before the short window ends, or it lands in the middle of a running tRFC. A wrong acceptance only shows up later, as a shifted fall of refPending. The stimulus therefore sends an early strobe during tXSNR and a second strobe on the cycle after the one that counts. It then checks that refPending falls on the exact cycle predicted from the counted strobe alone. A second round trip through self refresh, with a refused request placed just after cmdReady, confirms that both windows and the obligation restart.

// File: rtl/sr_exit_pkg.sv
package sr_exit_pkg;

  typedef enum logic {
    ST_SLEEP = 1'b0,
    ST_AWAKE = 1'b1
  } srxState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic countEn;   // exit windows run while set, reload while clear
    logic rfcLoad;   // start a tRFC recovery window
  } srxStrobe_t;

  typedef struct packed {
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
  } ddrCmd_t;

  localparam ddrCmd_t CMD_NOP      = '{csN: 1'b0, rasN: 1'b1, casN: 1'b1, weN: 1'b1};
  localparam ddrCmd_t CMD_DESELECT = '{csN: 1'b1, rasN: 1'b1, casN: 1'b1, weN: 1'b1};
  localparam ddrCmd_t CMD_SR_ENTER = '{csN: 1'b0, rasN: 1'b0, casN: 1'b0, weN: 1'b1};

endpackage

// File: rtl/sr_exit_timer.sv
module sr_exit_timer #(
  parameter int LEN        = 8,
  parameter bit START_FULL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic dec,
  output logic zero
);
  localparam int W = $clog2(LEN + 1);
  localparam logic [W-1:0] FULL = W'(LEN);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= START_FULL ? FULL : '0;
    end else if (load) begin
      cnt <= FULL;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sr_exit_dp.sv
module sr_exit_dp
  import sr_exit_pkg::*;
#(
  parameter int XSNR_CYC = 8,
  parameter int XSRD_CYC = 20,
  parameter int RFC_CYC  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  srxStrobe_t strb,
  output logic       xsnrDone,
  output logic       xsrdDone,
  output logic       rfcBusy
);
  localparam int NUM_WIN = 2;
  localparam int WIN_LEN [NUM_WIN] = '{XSNR_CYC, XSRD_CYC};

  logic [NUM_WIN-1:0] winZero;
  logic               rfcZero;

  // both exit windows: held full while asleep, count down once awake
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    sr_exit_timer #(.LEN(WIN_LEN[g]), .START_FULL(1'b1)) u_win (
      .clk  (clk),
      .rstN (rstN),
      .load (!strb.countEn),
      .dec  (strb.countEn),
      .zero (winZero[g])
    );
  end

  sr_exit_timer #(.LEN(RFC_CYC), .START_FULL(1'b0)) u_rfc (
    .clk  (clk),
    .rstN (rstN),
    .load (strb.rfcLoad),
    .dec  (1'b1),
    .zero (rfcZero)
  );

  assign xsnrDone = winZero[0];
  assign xsrdDone = winZero[1];
  assign rfcBusy  = !rfcZero;
endmodule

// File: rtl/sr_exit_ctrl.sv
module sr_exit_ctrl
  import sr_exit_pkg::*;
#(
  parameter bit IDLE_DESELECT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       exitReq,
  input  logic       clkStable,
  input  logic       reentryReq,
  input  logic       refIssued,
  input  logic       xsnrDone,
  input  logic       xsrdDone,
  input  logic       rfcBusy,
  output srxStrobe_t strb,
  output logic       ckeOut,
  output logic       odtAllow,
  output logic       cmdReady,
  output logic       refPending,
  output logic       reentryErr,
  output ddrCmd_t    cmdOut
);
  srxState_t state;
  logic      awaitRef;
  logic      entryCyc;
  logic      awake;
  logic      exitGo;
  logic      refAccept;
  logic      reenterOk;
  ddrCmd_t   idleCmd;

  if (IDLE_DESELECT) begin : g_idle_desel
    assign idleCmd = CMD_DESELECT;
  end else begin : g_idle_nop
    assign idleCmd = CMD_NOP;
  end

  assign awake      = (state == ST_AWAKE);
  assign cmdReady   = awake && xsnrDone;
  assign odtAllow   = awake && xsrdDone;
  assign refPending = awaitRef || rfcBusy;
  assign exitGo     = !awake && exitReq && clkStable;
  assign refAccept  = refIssued && cmdReady && !rfcBusy;
  assign reenterOk  = reentryReq && cmdReady && !refPending;

  always_comb begin
    strb         = '0;
    strb.countEn = awake;
    strb.rfcLoad = refAccept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_SLEEP;
      awaitRef   <= 1'b0;
      entryCyc   <= 1'b0;
      reentryErr <= 1'b0;
    end else begin
      entryCyc   <= reenterOk;
      reentryErr <= reentryReq && !reenterOk;
      if (exitGo) begin
        state    <= ST_AWAKE;
        awaitRef <= 1'b1;
      end else if (reenterOk) begin
        state    <= ST_SLEEP;
      end
      if (refAccept) begin
        awaitRef <= 1'b0;
      end
    end
  end

  assign ckeOut = awake;
  assign cmdOut = entryCyc ? CMD_SR_ENTER : idleCmd;
endmodule

// File: rtl/sr_exit_seq.sv
module sr_exit_seq
  import sr_exit_pkg::*;
#(
  parameter int XSNR_CYC      = 8,
  parameter int XSRD_CYC      = 20,
  parameter int RFC_CYC       = 6,
  parameter bit IDLE_DESELECT = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic exitReq,
  input  logic clkStable,
  input  logic reentryReq,
  input  logic refIssued,
  output logic ckeOut,
  output logic odtAllow,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic cmdReady,
  output logic refPending,
  output logic reentryErr
);
  srxStrobe_t strb;
  ddrCmd_t    cmdOut;
  logic       xsnrDone;
  logic       xsrdDone;
  logic       rfcBusy;

  sr_exit_ctrl #(.IDLE_DESELECT(IDLE_DESELECT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .exitReq    (exitReq),
    .clkStable  (clkStable),
    .reentryReq (reentryReq),
    .refIssued  (refIssued),
    .xsnrDone   (xsnrDone),
    .xsrdDone   (xsrdDone),
    .rfcBusy    (rfcBusy),
    .strb       (strb),
    .ckeOut     (ckeOut),
    .odtAllow   (odtAllow),
    .cmdReady   (cmdReady),
    .refPending (refPending),
    .reentryErr (reentryErr),
    .cmdOut     (cmdOut)
  );

  sr_exit_dp #(
    .XSNR_CYC (XSNR_CYC),
    .XSRD_CYC (XSRD_CYC),
    .RFC_CYC  (RFC_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .xsnrDone (xsnrDone),
    .xsrdDone (xsrdDone),
    .rfcBusy  (rfcBusy)
  );

  assign csN  = cmdOut.csN;
  assign rasN = cmdOut.rasN;
  assign casN = cmdOut.casN;
  assign weN  = cmdOut.weN;
endmodule

// File: rtl/sr_exit_chk.sv
module sr_exit_chk #(
  parameter int XSNR_CYC = 8,
  parameter int XSRD_CYC = 20
) (
  input logic clk,
  input logic rstN,
  input logic exitReq,
  input logic clkStable,
  input logic reentryReq,
  input logic ckeOut,
  input logic odtAllow,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic cmdReady,
  input logic refPending,
  input logic reentryErr
);
  localparam int SAT = (XSNR_CYC > XSRD_CYC ? XSNR_CYC : XSRD_CYC) + 1;

  int highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       highCnt <= 0;
    else if (!ckeOut) highCnt <= 0;
    else if (highCnt < SAT) highCnt <= highCnt + 1;
  end

  // R2
  cke_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ckeOut) |-> $past(exitReq && clkStable));

  // R3
  ready_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady == (ckeOut && (highCnt >= XSNR_CYC)));

  // R4
  odt_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    odtAllow == (ckeOut && (highCnt >= XSRD_CYC)));

  // R5
  idle_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    ckeOut |-> (rasN && casN && weN));

  // R6
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeOut) |-> $past(reentryReq && cmdReady && !refPending));

  // R7
  pend_on_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ckeOut) |-> refPending);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    reentryErr |-> $past(reentryReq));

  // R9
  entry_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeOut) |-> (!csN && !rasN && !casN && weN));
endmodule

bind sr_exit_seq sr_exit_chk #(.XSNR_CYC(XSNR_CYC), .XSRD_CYC(XSRD_CYC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .exitReq    (exitReq),
  .clkStable  (clkStable),
  .reentryReq (reentryReq),
  .ckeOut     (ckeOut),
  .odtAllow   (odtAllow),
  .csN        (csN),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN),
  .cmdReady   (cmdReady),
  .refPending (refPending),
  .reentryErr (reentryErr)
);

// File: tb/sr_exit_seq_bench.sv
`timescale 1ns/1ps
module sr_exit_seq_bench;
  localparam int XSNR = 8;
  localparam int XSRD = 20;
  localparam int RFC  = 6;

  localparam int B_WE = 0, B_CAS = 1, B_RAS = 2, B_CS = 3, B_ERR = 4;
  localparam int B_PEND = 5, B_RDY = 6, B_ODT = 7, B_CKE = 8, B_CS2 = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic exitReq = 1'b0, clkStable = 1'b0, reentryReq = 1'b0, refIssued = 1'b0;
  logic ckeOut, odtAllow, csN, rasN, casN, weN, cmdReady, refPending, reentryErr;
  logic cke2, odt2, cs2, ras2, cas2, we2, rdy2, pend2, err2;

  always #2.5 clk = ~clk;

  sr_exit_seq #(.XSNR_CYC(XSNR), .XSRD_CYC(XSRD), .RFC_CYC(RFC), .IDLE_DESELECT(1'b0)) u_sr_exit_seq (
    .clk(clk), .rstN(rstN), .exitReq(exitReq), .clkStable(clkStable),
    .reentryReq(reentryReq), .refIssued(refIssued), .ckeOut(ckeOut), .odtAllow(odtAllow),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .cmdReady(cmdReady),
    .refPending(refPending), .reentryErr(reentryErr));

  // deselect variant, same stimulus, only its chip select is scored
  sr_exit_seq #(.XSNR_CYC(XSNR), .XSRD_CYC(XSRD), .RFC_CYC(RFC), .IDLE_DESELECT(1'b1)) u_sr_exit_seq_desel (
    .clk(clk), .rstN(rstN), .exitReq(exitReq), .clkStable(clkStable),
    .reentryReq(reentryReq), .refIssued(refIssued), .ckeOut(cke2), .odtAllow(odt2),
    .csN(cs2), .rasN(ras2), .casN(cas2), .weN(we2), .cmdReady(rdy2),
    .refPending(pend2), .reentryErr(err2));

  typedef struct {
    int    at;
    int    sigBit;
    logic  val;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  logic [9:0] obs;

  assign obs = {cs2, ckeOut, odtAllow, cmdReady, refPending, reentryErr, csN, rasN, casN, weN};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectAt(input int at, input int sigBit, input logic val, input string tag);
    expItem_t it;
    it.at = at; it.sigBit = sigBit; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic waitTo(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: pop every expectation due this cycle and compare
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].at == cyc) begin
        compared++;
        if (obs[expQ[i].sigBit] !== expQ[i].val) begin
          mismatched++;
          $display("FAIL %s cycle %0d bit %0d: actual %b expected %b",
                   expQ[i].tag, cyc, expQ[i].sigBit, obs[expQ[i].sigBit], expQ[i].val);
        end
        expQ.delete(i);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int r, e, f, n, e2;
    repeat (3) @(negedge clk);
    r = cyc;
    rstN = 1'b1;
    // R1 reset state, R5 idle encodings for both variants
    expectAt(r+1, B_CKE, 1'b0, "R1 cke");
    expectAt(r+1, B_ODT, 1'b0, "R1 odt");
    expectAt(r+1, B_RDY, 1'b0, "R1 rdy");
    expectAt(r+1, B_PEND, 1'b0, "R1 pend");
    expectAt(r+1, B_ERR, 1'b0, "R1 err");
    expectAt(r+1, B_CS, 1'b0, "R5 nop cs");
    expectAt(r+1, B_RAS, 1'b1, "R5 ras");
    expectAt(r+1, B_CS2, 1'b1, "R5 deselect cs");

    // R2 exit asked without a stable clock
    waitTo(r+1);
    exitReq = 1'b1;
    expectAt(r+2, B_CKE, 1'b0, "R2 no stable clock");
    expectAt(r+4, B_CKE, 1'b0, "R2 no stable clock");
    waitTo(r+2);
    reentryReq = 1'b1;          // R8 refused while asleep
    expectAt(r+3, B_ERR, 1'b1, "R8 asleep");
    expectAt(r+4, B_ERR, 1'b0, "R8 single pulse");
    waitTo(r+3);
    reentryReq = 1'b0;
    waitTo(r+4);
    clkStable = 1'b1;
    e = r + 5;
    expectAt(e, B_CKE, 1'b1, "R2 cke rises");
    expectAt(e, B_PEND, 1'b1, "R7 pend on exit");
    expectAt(e+1, B_CS2, 1'b1, "R5 deselect during exit");
    expectAt(e+3, B_WE, 1'b1, "R5 idle during exit");
    expectAt(e+XSNR-1, B_RDY, 1'b0, "R3 before tXSNR");
    expectAt(e+XSNR, B_RDY, 1'b1, "R3 at tXSNR");
    expectAt(e+XSRD-1, B_ODT, 1'b0, "R4 before tXSRD");
    expectAt(e+XSRD, B_ODT, 1'b1, "R4 at tXSRD");
    waitTo(e);
    exitReq = 1'b0;

    // early refresh inside tXSNR must not count (R7), early re-entry refused (R8)
    waitTo(e+2);
    refIssued = 1'b1;
    waitTo(e+3);
    refIssued = 1'b0;
    reentryReq = 1'b1;
    expectAt(e+4, B_ERR, 1'b1, "R8 before tXSNR");
    expectAt(e+5, B_CKE, 1'b1, "R6 cke held after refusal");
    expectAt(e+10, B_PEND, 1'b1, "R7 early refresh ignored");
    waitTo(e+4);
    reentryReq = 1'b0;

    // counted refresh, plus one during tRFC that must be ignored
    waitTo(e+XSNR);
    refIssued = 1'b1;
    f = e + XSNR + 1;
    expectAt(f+RFC-1, B_PEND, 1'b1, "R7 tRFC running");
    expectAt(f+RFC, B_PEND, 1'b0, "R7 cleared after tRFC");
    waitTo(e+XSNR+1);
    waitTo(e+XSNR+2);
    refIssued = 1'b0;

    // accepted re-entry
    n = e + XSRD + 2;
    waitTo(n);
    reentryReq = 1'b1;
    expectAt(n+1, B_CKE, 1'b0, "R9 cke low");
    expectAt(n+1, B_CS, 1'b0, "R9 entry cs");
    expectAt(n+1, B_RAS, 1'b0, "R9 entry ras");
    expectAt(n+1, B_CAS, 1'b0, "R9 entry cas");
    expectAt(n+1, B_WE, 1'b1, "R9 entry we");
    expectAt(n+1, B_RDY, 1'b0, "R9 rdy low");
    expectAt(n+1, B_ODT, 1'b0, "R9 odt low");
    expectAt(n+1, B_ERR, 1'b0, "R9 no error");
    expectAt(n+2, B_RAS, 1'b1, "R5 idle after entry");
    expectAt(n+2, B_CAS, 1'b1, "R5 idle after entry");
    expectAt(n+2, B_CKE, 1'b0, "R9 stays asleep");
    waitTo(n+1);
    reentryReq = 1'b0;

    // second exit: everything restarts
    waitTo(n+2);
    exitReq = 1'b1;
    e2 = n + 3;
    expectAt(e2, B_CKE, 1'b1, "R10 second exit");
    expectAt(e2, B_PEND, 1'b1, "R10 obligation restarts");
    expectAt(e2+XSNR-1, B_RDY, 1'b0, "R10 tXSNR restarts");
    expectAt(e2+XSNR, B_RDY, 1'b1, "R10 tXSNR end");
    expectAt(e2+XSNR, B_ODT, 1'b0, "R10 tXSRD restarts");
    waitTo(e2);
    exitReq = 1'b0;
    waitTo(e2+XSNR);
    reentryReq = 1'b1;          // refused: refresh still owed
    expectAt(e2+XSNR+1, B_ERR, 1'b1, "R8 refresh owed");
    expectAt(e2+XSNR+2, B_CKE, 1'b1, "R6 cke held");
    waitTo(e2+XSNR+1);
    reentryReq = 1'b0;

    waitTo(e2+XSNR+5);
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: actual %0d unchecked expected 0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule